// File: doc/BRIEF.md
# Active Priority Stack Tracker

This block keeps, for each processor it serves, the preemption state of interrupts that have been accepted but not yet completed. When a processor accepts an interrupt, the tracker reduces the interrupt's 8-bit priority to a group priority under a binary-point setting. It marks the resulting preemption level in one of two active-level bitmaps, one for secure (group 0) and one for non-secure (group 1) interrupts. The accepted group priority becomes the processor's running priority. When the processor signals end of interrupt, the most urgent active level of that interrupt's group is cleared, and the running priority is rebuilt from whatever levels remain active in either bitmap.

The running priority gates further acceptance. An interrupt is accepted only if its priority is strictly more urgent (numerically lower) than the running priority, so nested handlers preempt only when they should. Every processor has its own independent copy of the state, and each copy has two binary-point registers, one per group. Pending-state management and register access are left to neighbouring logic, which drives the strobes and reads the outputs.

Top module: `active_prio_tracker`

## Requirements
- R1: After reset every processor reports running priority 0x100 (idle), both binary points equal the configured minimum (default 3), and no level is active.
- R2: The group priority of an accepted interrupt is its priority ANDed with 0xFF shifted left by (binary point + 1). Group 0 uses the secure binary point and group 1 uses the non-secure one. On acceptance the running priority becomes that group priority.
- R3: An acknowledge is granted only when its 8-bit priority is strictly below the running priority. A granted acknowledge returns its own ID on the response, and a refused one returns 1023.
- R4: A granted acknowledge marks preemption level (group priority >> (minimum binary point + 1)) in the non-secure bitmap for group 1 (group flag 1) or in the secure bitmap for group 0 (group flag 0).
- R5: An end of interrupt clears the lowest-numbered set level in its own group's bitmap. The running priority then becomes the lowest set level across both bitmaps shifted left by (minimum binary point + 1), or 0x100 when none is set.
- R6: An end of interrupt has no effect when its ID is not below the source count (default 96) or when the running priority is already 0x100.
- R7: A refused acknowledge changes neither the running priority nor the bitmaps.
- R8: A binary-point write keeps the low 3 bits and raises any value below the minimum to the minimum. Select 0 writes the secure point and select 1 writes the non-secure point. A write takes effect in the next cycle.
- R9: When an end of interrupt and an acknowledge arrive together for one processor, the end of interrupt is applied first, and the grant decision compares against the running priority that results.
- R10: Each processor's state is changed only by that processor's own strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ack_valid | input | NUM_CPU | Acknowledge strobe per processor |
| ack_prio | input | NUM_CPU x 8 | Priority of the interrupt offered for acknowledge |
| ack_group | input | NUM_CPU | Group of that interrupt (1 = non-secure) |
| ack_id | input | NUM_CPU x 10 | ID of that interrupt |
| ack_grant | output | NUM_CPU | Acknowledge accepted this cycle |
| ack_resp_id | output | NUM_CPU x 10 | Returned ID, 1023 when refused |
| eoi_valid | input | NUM_CPU | End-of-interrupt strobe per processor |
| eoi_id | input | NUM_CPU x 10 | ID being completed |
| eoi_group | input | NUM_CPU | Group of the completed interrupt |
| bp_wr_en | input | NUM_CPU | Binary-point write strobe |
| bp_wr_sel | input | NUM_CPU | 0 selects secure point, 1 non-secure |
| bp_wr_data | input | NUM_CPU x 3 | Value written |
| bp_s | output | NUM_CPU x 3 | Current secure binary point |
| bp_ns | output | NUM_CPU x 3 | Current non-secure binary point |
| running_prio | output | NUM_CPU x 9 | Running priority, 0x100 when idle |

## Verification
Directed nesting sequences stack secure and non-secure acknowledges and then complete them out of group order. This separates per-group clearing from clearing across the combined bitmap. An acknowledge at exactly the running priority and one just below it pin the strict comparison. A completion issued together with an acknowledge that would be refused against the old running priority shows whether the completion is applied first. Random traffic on both processors then mixes out-of-range IDs, idle completions and binary-point writes. That exercises masking at every binary point and confirms that one processor's strobes leave the other's state alone.

// File: rtl/apt_pkg.sv
// Package: shared widths, constants and helpers for the active priority tracker.
// Assumes 8-bit priorities and 10-bit interrupt IDs.
package apt_pkg;
    localparam int PRIO_W = 8;
    localparam int ID_W   = 10;
    localparam int RUN_W  = PRIO_W + 1;
    localparam int BP_W   = 3;

    localparam logic [RUN_W-1:0] IDLE_PRIO   = 9'h100;
    localparam logic [ID_W-1:0]  SPURIOUS_ID = 10'd1023;

    // Raise a written binary point to the floor if it falls below it.
    function automatic logic [BP_W-1:0] clamp_bp(input logic [BP_W-1:0] v,
                                                 input logic [BP_W-1:0] floor_v);
        return (v < floor_v) ? floor_v : v;
    endfunction
endpackage

// File: rtl/apt_group_prio.sv
// Group priority and preemption level of one interrupt.
// Masks the priority bits below the binary point and turns what remains into a
// level index and its one-hot form. Assumes MIN_BP is at most 6.
module apt_group_prio #(
    parameter int MIN_BP = 3,
    localparam int LVL_W  = 7 - MIN_BP,
    localparam int LEVELS = 1 << LVL_W
) (
    input  logic [7:0]        prio,
    input  logic [2:0]        bp,
    output logic [7:0]        gprio,
    output logic [LVL_W-1:0]  level,
    output logic [LEVELS-1:0] level_onehot
);
    logic [15:0] mask_wide;

    // Build the mask from the binary point, then derive the level.
    always_comb begin
        mask_wide    = 16'hFFFF << ({1'b0, bp} + 4'd1);
        gprio        = prio & mask_wide[7:0];
        level        = gprio[7:MIN_BP+1];
        level_onehot = LEVELS'(1) << level;
    end
endmodule

// File: rtl/apt_lowest_set.sv
// Finds the lowest set bit of a vector and reports its index.
// Assumes W is a power of two with IDX_W = log2(W).
module apt_lowest_set #(
    parameter int W     = 16,
    parameter int IDX_W = 4
) (
    input  logic [W-1:0]     vec,
    output logic             found,
    output logic [IDX_W-1:0] idx
);
    // Scan from the top so the last hit is the lowest set bit.
    always_comb begin
        idx = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec[i]) idx = IDX_W'(i);
        end
        found = |vec;
    end
endmodule

// File: rtl/apt_cpu_tracker.sv
// Per-processor active priority state.
// Holds a secure and a non-secure bitmap of active preemption levels, the
// running priority and two binary points. Applies end of interrupt before
// acknowledge within one cycle. Assumes the two strobes nest correctly.
module apt_cpu_tracker
    import apt_pkg::*;
#(
    parameter int NUM_SRC = 96,
    parameter int MIN_BP  = 3,
    localparam int LVL_W  = 7 - MIN_BP,
    localparam int LEVELS = 1 << LVL_W,
    localparam logic [ID_W:0] SRC_LIMIT = (ID_W + 1)'(NUM_SRC),
    localparam logic [BP_W-1:0] BP_FLOOR = BP_W'(MIN_BP)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_valid,
    input  logic [7:0]       ack_prio,
    input  logic             ack_group,
    input  logic [ID_W-1:0]  ack_id,
    output logic             ack_grant,
    output logic [ID_W-1:0]  ack_resp_id,
    input  logic             eoi_valid,
    input  logic [ID_W-1:0]  eoi_id,
    input  logic             eoi_group,
    input  logic             bp_wr_en,
    input  logic             bp_wr_sel,
    input  logic [BP_W-1:0]  bp_wr_data,
    output logic [BP_W-1:0]  bp_s,
    output logic [BP_W-1:0]  bp_ns,
    output logic [RUN_W-1:0] running_prio
);
    logic [LEVELS-1:0] map_s, map_ns;
    logic [RUN_W-1:0]  run_q;
    logic [BP_W-1:0]   bp_s_q, bp_ns_q;

    logic              eoi_take, eoi_found, eoi_fire;
    logic [LEVELS-1:0] eoi_map, eoi_bit;
    logic [LVL_W-1:0]  eoi_idx;
    logic [LEVELS-1:0] mid_s, mid_ns;
    logic              rest_found;
    logic [LVL_W-1:0]  rest_idx;
    logic [RUN_W-1:0]  mid_run;
    logic [BP_W-1:0]   bp_use;
    logic [7:0]        gprio;
    logic [LVL_W-1:0]  ack_level;
    logic [LEVELS-1:0] ack_onehot;
    logic [LEVELS-1:0] nxt_s, nxt_ns;
    logic [RUN_W-1:0]  nxt_run;

    // Decide whether the end of interrupt counts and pick its group's bitmap.
    always_comb begin
        eoi_take = eoi_valid && ({1'b0, eoi_id} < SRC_LIMIT) && (run_q != IDLE_PRIO);
        eoi_map  = eoi_group ? map_ns : map_s;
    end

    apt_lowest_set #(.W(LEVELS), .IDX_W(LVL_W)) u_eoi_pick (
        .vec   (eoi_map),
        .found (eoi_found),
        .idx   (eoi_idx)
    );

    // Clear the most urgent active level of the completing group.
    always_comb begin
        eoi_fire = eoi_take && eoi_found;
        eoi_bit  = LEVELS'(1) << eoi_idx;
        mid_s    = map_s  & ~((eoi_fire && !eoi_group) ? eoi_bit : '0);
        mid_ns   = map_ns & ~((eoi_fire &&  eoi_group) ? eoi_bit : '0);
    end

    apt_lowest_set #(.W(LEVELS), .IDX_W(LVL_W)) u_run_pick (
        .vec   (mid_s | mid_ns),
        .found (rest_found),
        .idx   (rest_idx)
    );

    // Running priority once the end of interrupt has been applied.
    always_comb begin
        if (!eoi_fire)       mid_run = run_q;
        else if (rest_found) mid_run = {1'b0, rest_idx, {(MIN_BP + 1){1'b0}}};
        else                 mid_run = IDLE_PRIO;
    end

    // Group priority of the offered interrupt under its group's binary point.
    always_comb bp_use = ack_group ? bp_ns_q : bp_s_q;

    apt_group_prio #(.MIN_BP(MIN_BP)) u_gprio (
        .prio         (ack_prio),
        .bp           (bp_use),
        .gprio        (gprio),
        .level        (ack_level),
        .level_onehot (ack_onehot)
    );

    // Grant on strict preemption, then mark the level and raise the running priority.
    always_comb begin
        ack_grant   = ack_valid && ({1'b0, ack_prio} < mid_run);
        ack_resp_id = ack_grant ? ack_id : SPURIOUS_ID;
        nxt_s       = mid_s  | ((ack_grant && !ack_group) ? ack_onehot : '0);
        nxt_ns      = mid_ns | ((ack_grant &&  ack_group) ? ack_onehot : '0);
        nxt_run     = ack_grant ? {1'b0, gprio} : mid_run;
    end

    // Active state registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_s  <= '0;
            map_ns <= '0;
            run_q  <= IDLE_PRIO;
        end else begin
            map_s  <= nxt_s;
            map_ns <= nxt_ns;
            run_q  <= nxt_run;
        end
    end

    // Binary point registers with floor clamp.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bp_s_q  <= BP_FLOOR;
            bp_ns_q <= BP_FLOOR;
        end else if (bp_wr_en) begin
            if (bp_wr_sel) bp_ns_q <= clamp_bp(bp_wr_data, BP_FLOOR);
            else           bp_s_q  <= clamp_bp(bp_wr_data, BP_FLOOR);
        end
    end

    assign bp_s         = bp_s_q;
    assign bp_ns        = bp_ns_q;
    assign running_prio = run_q;

    AST_IDLE_MEANS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        ((map_s == '0) && (map_ns == '0)) == (run_q == IDLE_PRIO)); // R5
    AST_GRANT_LOWERS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_grant && !eoi_valid) |=> (run_q < $past(run_q))); // R3
    AST_REFUSE_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_valid && !ack_grant && !eoi_valid) |=>
            ($stable(run_q) && $stable(map_s) && $stable(map_ns))); // R7
    AST_BP_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (bp_s_q >= BP_FLOOR) && (bp_ns_q >= BP_FLOOR)); // R8
    AST_EOI_BAD_ID: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && ({1'b0, eoi_id} >= SRC_LIMIT) && !ack_valid) |=> $stable(run_q)); // R6
    AST_EOI_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_valid && !ack_valid) |=>
            (($countones(map_s) + $countones(map_ns)) <=
             $past($countones(map_s) + $countones(map_ns)))); // R5
endmodule

// File: rtl/active_prio_tracker.sv
// Top: one active priority tracker per processor, sharing no state.
// Assumes every processor's strobes are synchronous to clk.
module active_prio_tracker
    import apt_pkg::*;
#(
    parameter int NUM_CPU = 2,
    parameter int NUM_SRC = 96,
    parameter int MIN_BP  = 3
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_CPU-1:0]              ack_valid,
    input  logic [NUM_CPU-1:0][7:0]         ack_prio,
    input  logic [NUM_CPU-1:0]              ack_group,
    input  logic [NUM_CPU-1:0][ID_W-1:0]    ack_id,
    output logic [NUM_CPU-1:0]              ack_grant,
    output logic [NUM_CPU-1:0][ID_W-1:0]    ack_resp_id,
    input  logic [NUM_CPU-1:0]              eoi_valid,
    input  logic [NUM_CPU-1:0][ID_W-1:0]    eoi_id,
    input  logic [NUM_CPU-1:0]              eoi_group,
    input  logic [NUM_CPU-1:0]              bp_wr_en,
    input  logic [NUM_CPU-1:0]              bp_wr_sel,
    input  logic [NUM_CPU-1:0][BP_W-1:0]    bp_wr_data,
    output logic [NUM_CPU-1:0][BP_W-1:0]    bp_s,
    output logic [NUM_CPU-1:0][BP_W-1:0]    bp_ns,
    output logic [NUM_CPU-1:0][RUN_W-1:0]   running_prio
);
    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        apt_cpu_tracker #(.NUM_SRC(NUM_SRC), .MIN_BP(MIN_BP)) u_trk (
            .clk          (clk),
            .rst_n        (rst_n),
            .ack_valid    (ack_valid[c]),
            .ack_prio     (ack_prio[c]),
            .ack_group    (ack_group[c]),
            .ack_id       (ack_id[c]),
            .ack_grant    (ack_grant[c]),
            .ack_resp_id  (ack_resp_id[c]),
            .eoi_valid    (eoi_valid[c]),
            .eoi_id       (eoi_id[c]),
            .eoi_group    (eoi_group[c]),
            .bp_wr_en     (bp_wr_en[c]),
            .bp_wr_sel    (bp_wr_sel[c]),
            .bp_wr_data   (bp_wr_data[c]),
            .bp_s         (bp_s[c]),
            .bp_ns        (bp_ns[c]),
            .running_prio (running_prio[c])
        );
    end
endmodule

// File: tb/tb_active_prio_tracker.sv
module tb_active_prio_tracker;
    localparam int NCPU  = 2;
    localparam int NSRC  = 96;
    localparam int MINBP = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic [NCPU-1:0]        ack_valid, ack_group, ack_grant;
    logic [NCPU-1:0][7:0]   ack_prio;
    logic [NCPU-1:0][9:0]   ack_id, ack_resp_id, eoi_id;
    logic [NCPU-1:0]        eoi_valid, eoi_group, bp_wr_en, bp_wr_sel;
    logic [NCPU-1:0][2:0]   bp_wr_data, bp_s, bp_ns;
    logic [NCPU-1:0][8:0]   running_prio;

    active_prio_tracker #(.NUM_CPU(NCPU), .NUM_SRC(NSRC), .MIN_BP(MINBP)) dut (
        .clk(clk), .rst_n(rst_n),
        .ack_valid(ack_valid), .ack_prio(ack_prio), .ack_group(ack_group), .ack_id(ack_id),
        .ack_grant(ack_grant), .ack_resp_id(ack_resp_id),
        .eoi_valid(eoi_valid), .eoi_id(eoi_id), .eoi_group(eoi_group),
        .bp_wr_en(bp_wr_en), .bp_wr_sel(bp_wr_sel), .bp_wr_data(bp_wr_data),
        .bp_s(bp_s), .bp_ns(bp_ns), .running_prio(running_prio)
    );

    int n_checks = 0;
    int n_fail = 0;
    string cur_tag = "R1";
    int m_run[NCPU];
    logic [15:0] m_s[NCPU];
    logic [15:0] m_ns[NCPU];
    int m_bps[NCPU];
    int m_bpns[NCPU];

    task automatic check(string tag, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic int low_idx(logic [15:0] v);
        for (int i = 0; i < 16; i++) if (v[i]) return i;
        return -1;
    endfunction

    function automatic int group_prio(int prio, int bp);
        return (prio >> (bp + 1)) << (bp + 1);
    endfunction

    task automatic clear_stim();
        ack_valid = '0; ack_group = '0; ack_prio = '0; ack_id = '0;
        eoi_valid = '0; eoi_group = '0; eoi_id = '0;
        bp_wr_en = '0; bp_wr_sel = '0; bp_wr_data = '0;
    endtask

    task automatic do_ack(int c, int prio, int grp, int id);
        ack_valid[c] = 1'b1; ack_prio[c] = 8'(prio); ack_group[c] = grp[0]; ack_id[c] = 10'(id);
    endtask

    task automatic do_eoi(int c, int id, int grp);
        eoi_valid[c] = 1'b1; eoi_id[c] = 10'(id); eoi_group[c] = grp[0];
    endtask

    task automatic do_bp(int c, int sel, int val);
        bp_wr_en[c] = 1'b1; bp_wr_sel[c] = sel[0]; bp_wr_data[c] = 3'(val);
    endtask

    // Called just after a falling edge with stimulus driven; advances one cycle.
    task automatic run_cycle();
        #1;
        for (int c = 0; c < NCPU; c++) begin
            int mid_run, k, l, bp, g, v;
            logic [15:0] ms, mn;
            bit grant;
            check(cur_tag, "running_prio", int'(running_prio[c]), m_run[c]);
            check(cur_tag, "bp_s", int'(bp_s[c]), m_bps[c]);
            check(cur_tag, "bp_ns", int'(bp_ns[c]), m_bpns[c]);
            ms = m_s[c]; mn = m_ns[c]; mid_run = m_run[c];
            if (eoi_valid[c] && int'(eoi_id[c]) < NSRC && m_run[c] != 256) begin
                k = low_idx(eoi_group[c] ? mn : ms);
                if (k >= 0) begin
                    if (eoi_group[c]) mn[k] = 1'b0; else ms[k] = 1'b0;
                    l = low_idx(ms | mn);
                    mid_run = (l < 0) ? 256 : (l << (MINBP + 1));
                end
            end
            bp = ack_group[c] ? m_bpns[c] : m_bps[c];
            g = group_prio(int'(ack_prio[c]), bp);
            grant = ack_valid[c] && (int'(ack_prio[c]) < mid_run);
            check(cur_tag, "ack_grant", int'(ack_grant[c]), int'(grant));
            check(cur_tag, "ack_resp_id", int'(ack_resp_id[c]), grant ? int'(ack_id[c]) : 1023);
            if (grant) begin
                if (ack_group[c]) mn[g >> (MINBP + 1)] = 1'b1;
                else              ms[g >> (MINBP + 1)] = 1'b1;
                mid_run = g;
            end
            if (bp_wr_en[c]) begin
                v = int'(bp_wr_data[c]);
                if (v < MINBP) v = MINBP;
                if (bp_wr_sel[c]) m_bpns[c] = v; else m_bps[c] = v;
            end
            m_s[c] = ms; m_ns[c] = mn; m_run[c] = mid_run;
        end
        @(negedge clk);
        clear_stim();
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        clear_stim();
        for (int c = 0; c < NCPU; c++) begin
            m_run[c] = 256; m_s[c] = '0; m_ns[c] = '0; m_bps[c] = MINBP; m_bpns[c] = MINBP;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state checked by the first cycle.
        cur_tag = "R1";
        run_cycle();

        // R2 and R4: group priority 0x55 -> 0x50 at the minimum point.
        cur_tag = "R2";
        do_ack(0, 8'h55, 0, 33);
        run_cycle();
        cur_tag = "R4";
        run_cycle();

        // R3: equal priority refused, one below granted.
        cur_tag = "R3";
        do_ack(0, 8'h50, 0, 40);
        run_cycle();
        cur_tag = "R7";
        do_ack(0, 8'h60, 1, 41);
        run_cycle();
        cur_tag = "R3";
        do_ack(0, 8'h4F, 0, 42);
        run_cycle();

        // R6: out-of-range ID ignored; then two completions; then idle completion.
        cur_tag = "R6";
        do_eoi(0, 200, 0);
        run_cycle();
        do_eoi(0, NSRC, 0);
        run_cycle();
        cur_tag = "R5";
        do_eoi(0, 5, 0);
        run_cycle();
        do_eoi(0, 6, 0);
        run_cycle();
        cur_tag = "R6";
        do_eoi(0, 7, 0);
        run_cycle();

        // R8: clamp below floor, keep above it, and effect on masking.
        cur_tag = "R8";
        do_bp(0, 0, 0);
        run_cycle();
        do_bp(0, 1, 6);
        run_cycle();
        do_ack(0, 8'hFF, 1, 9);
        run_cycle();
        do_eoi(0, 9, 1);
        do_bp(0, 1, 2);
        run_cycle();
        cur_tag = "R2";
        do_bp(0, 0, 5);
        run_cycle();
        do_ack(0, 8'hB7, 0, 10);
        run_cycle();
        do_eoi(0, 10, 0);
        do_bp(0, 0, 3);
        run_cycle();

        // R5: per-group clearing with nested secure and non-secure levels.
        cur_tag = "R5";
        do_ack(0, 8'h60, 0, 11);
        run_cycle();
        do_ack(0, 8'h20, 1, 12);
        run_cycle();
        do_eoi(0, 11, 0);
        run_cycle();
        do_eoi(0, 12, 1);
        run_cycle();
        run_cycle();

        // R9: completion applied before a same-cycle acknowledge.
        cur_tag = "R9";
        do_ack(0, 8'h30, 0, 13);
        run_cycle();
        do_eoi(0, 13, 0);
        do_ack(0, 8'h40, 0, 14);
        run_cycle();
        do_eoi(0, 14, 0);
        run_cycle();

        // R10: activity on processor 1 leaves processor 0 unchanged.
        cur_tag = "R10";
        do_ack(1, 8'h10, 1, 15);
        do_bp(1, 0, 7);
        run_cycle();
        run_cycle();
        do_eoi(1, 15, 1);
        run_cycle();

        // Random mix on both processors.
        for (int n = 0; n < 4000; n++) begin
            for (int c = 0; c < NCPU; c++) begin
                if ($urandom_range(1, 0) == 1) do_ack(c, $urandom_range(255, 0), $urandom_range(1, 0), $urandom_range(1023, 0));
                if ($urandom_range(2, 0) == 0)
                    do_eoi(c, ($urandom_range(7, 0) == 0) ? $urandom_range(1023, NSRC) : $urandom_range(NSRC - 1, 0),
                           $urandom_range(1, 0));
                if ($urandom_range(9, 0) == 0) do_bp(c, $urandom_range(1, 0), $urandom_range(7, 0));
            end
            run_cycle();
        end
        run_cycle();
        finish_run();
    end
endmodule